// File: doc/BRIEF.md
# Low-Frequency Sleep Timer with Two Compare Channels

This block keeps system time while the rest of the chip sleeps. It counts low-rate tick enables from one of two sources: a calibrated 1 kHz reference or a 32.768 kHz crystal tick. A programmable power-of-two prescaler divides the selected source, and each prescaled tick advances a free-running counter by one. The counter is 32 bits wide by default and sets the width `CNT_W`.

Two compare channels and a rollover detector watch the counter. Each one sets its own sticky flag. Software clears a flag by pulsing a one on the matching bit of the clear input. Two separate masks route every flag to an interrupt line and to a wake line.

A debug-halt input can freeze the timer, but only when the freeze enable is set. With the enable clear, a halt has no effect on counting. The tick inputs are single-cycle enables in the block clock domain. All pins are plain control and status signals. No stream is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `sleep_timer`

## Requirements
- R1: `count` starts at zero. It changes only by stepping up one, modulo 2^CNT_W, on a prescaled tick, and the new value shows on the clock edge that accepts the tick.
- R2: `src_sel` = 0 selects `tick_1k` and `src_sel` = 1 selects `tick_32k`. Pulses on the unselected tick input have no effect on `count` or on the prescaler.
- R3: With exponent N on `pre_exp` (0 to 15), `count` advances once per 2^N accepted ticks of the selected source. N = 0 passes every tick through.
- R4: In any cycle where `src_sel` or `pre_exp` differs from its value in the previous cycle, the prescaler restarts from zero. The tick in that cycle is dropped and `count` keeps its value.
- R5: Flag bit i (i = 0 for `cmp0_val`, i = 1 for `cmp1_val`) sets on the edge where `count` steps up to equal that compare value. A compare value that `count` already holds without stepping sets nothing.
- R6: Flag bit 2 sets on the edge where `count` rolls from all-ones to zero.
- R7: Flags are sticky. A one on a bit of `flag_clr` clears that flag on the next edge. A set arriving in the same cycle as a clear wins.
- R8: `irq` is the OR of `flags & irq_en` and `wake` is the OR of `flags & wake_en`. Both follow the flags and masks with no added register.
- R9: While `dbg_halt` and `freeze_en` are both 1, selected ticks are ignored and `count` and the prescaler hold. With `freeze_en` = 0, `dbg_halt` changes nothing.
- R10: During reset (`rst_n` low), `count` and `flags` are zero, `irq` and `wake` are low, and the remembered source and exponent are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle enable at the 1 kHz reference rate |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz crystal rate |
| src_sel | input | 1 | Tick source: 0 = 1 kHz, 1 = 32.768 kHz |
| pre_exp | input | EXP_W | Prescaler exponent N; divide by 2^N |
| cmp0_val | input | CNT_W | Compare value, channel 0 |
| cmp1_val | input | CNT_W | Compare value, channel 1 |
| irq_en | input | 3 | Interrupt mask: bit 0 cmp0, bit 1 cmp1, bit 2 wrap |
| wake_en | input | 3 | Wake mask, same bit layout |
| flag_clr | input | 3 | Write-one-to-clear pulses, same bit layout |
| dbg_halt | input | 1 | Debugger halt indication |
| freeze_en | input | 1 | Allows `dbg_halt` to freeze the timer |
| count | output | CNT_W | Counter value |
| flags | output | 3 | Sticky event flags |
| irq | output | 1 | Masked interrupt request |
| wake | output | 1 | Masked wake request |

## Verification
The bench builds the timer with `CNT_W` = 8 and keeps `EXP_W` = 4. A rollover then takes only 256 prescaled ticks, so the wrap flag and the modulo step on `count` come within a short run. The full 4-bit exponent is still there, so the largest divide of 2^15 is run end to end and shows a single step after 32768 continuous ticks. The narrow counter also lets both compare channels be placed just ahead of the count, and the same-cycle set/clear case can be hit.

// File: rtl/sleep_timer_pkg.sv
package sleep_timer_pkg;
  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } tick_src_e;

  localparam int EVT_PER_CMP = 1;
endpackage

// File: rtl/st_prescaler.sv
module st_prescaler
  import sleep_timer_pkg::*;
#(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             src_sel,
  input  logic [EXP_W-1:0] pre_exp,
  input  logic             freeze,
  output logic             inc
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic             src_q;
  logic [EXP_W-1:0] exp_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W:0]   one_hot_m1;
  logic [PRE_W-1:0] term;
  logic             cfg_chg;
  logic             tick_sel;
  logic             advance;
  logic             at_term;

  always_comb begin
    cfg_chg    = (src_sel != src_q) || (pre_exp != exp_q);
    tick_sel   = (tick_src_e'(src_sel) == SRC_FAST) ? tick_fast : tick_slow;
    one_hot    = (PRE_W+1)'(1) << pre_exp;
    one_hot_m1 = one_hot - (PRE_W+1)'(1);
    term       = one_hot_m1[PRE_W-1:0];
    at_term    = (pre_cnt == term);
    advance    = tick_sel && !freeze && !cfg_chg;
    inc        = advance && at_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      exp_q   <= '0;
      pre_cnt <= '0;
    end else begin
      src_q <= src_sel;
      exp_q <= pre_exp;
      if (cfg_chg)      pre_cnt <= '0;
      else if (advance) pre_cnt <= at_term ? '0 : pre_cnt + PRE_W'(1);
    end
  end

  assert_restart_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (pre_cnt == '0));

  assert_pass_all_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (pre_exp == '0 && advance) |-> inc);

  assert_in_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> (pre_cnt <= term));

  assert_frozen_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cfg_chg) |=> $stable(pre_cnt));
endmodule

// File: rtl/st_counter.sv
module st_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_flat,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_CMP-1:0]       cmp_hit,
  output logic                     wrap_hit
);
  logic [CNT_W-1:0] nxt;

  assign nxt      = count + CNT_W'(1);
  assign wrap_hit = inc && (&count);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign cmp_hit[i] = inc && (nxt == cmp_flat[i*CNT_W +: CNT_W]);

    assert_hit_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |=> (count == $past(cmp_flat[i*CNT_W +: CNT_W])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= nxt;
  end

  assert_step_one_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)));

  assert_hold_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

  assert_wrap_zero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> (count == '0));
endmodule

// File: rtl/st_flags.sv
module st_flags #(
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_evt,
  input  logic [NUM_EVT-1:0] clr,
  input  logic [NUM_EVT-1:0] irq_en,
  input  logic [NUM_EVT-1:0] wake_en,
  output logic [NUM_EVT-1:0] flags,
  output logic               irq,
  output logic               wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set_evt;
  end

  assign irq  = |(flags & irq_en);
  assign wake = |(flags & wake_en);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    assert_sticky_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
    assert_set_wins_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    assert_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set_evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/sleep_timer.sv
module sleep_timer #(
  parameter int CNT_W = 32,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1k,
  input  logic             tick_32k,
  input  logic             src_sel,
  input  logic [EXP_W-1:0] pre_exp,
  input  logic [CNT_W-1:0] cmp0_val,
  input  logic [CNT_W-1:0] cmp1_val,
  input  logic [2:0]       irq_en,
  input  logic [2:0]       wake_en,
  input  logic [2:0]       flag_clr,
  input  logic             dbg_halt,
  input  logic             freeze_en,
  output logic [CNT_W-1:0] count,
  output logic [2:0]       flags,
  output logic             irq,
  output logic             wake
);
  localparam int NUM_CMP = 2;
  localparam int NUM_EVT = NUM_CMP + 1;

  logic                 frozen;
  logic                 inc;
  logic [NUM_CMP-1:0]   cmp_hit;
  logic                 wrap_hit;
  logic [NUM_EVT-1:0]   set_evt;

  assign frozen  = dbg_halt && freeze_en;
  assign set_evt = {wrap_hit, cmp_hit};

  st_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_slow (tick_1k),
    .tick_fast (tick_32k),
    .src_sel   (src_sel),
    .pre_exp   (pre_exp),
    .freeze    (frozen),
    .inc       (inc)
  );

  st_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .cmp_flat ({cmp1_val, cmp0_val}),
    .count    (count),
    .cmp_hit  (cmp_hit),
    .wrap_hit (wrap_hit)
  );

  st_flags #(.NUM_EVT(NUM_EVT)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr     (flag_clr),
    .irq_en  (irq_en),
    .wake_en (wake_en),
    .flags   (flags),
    .irq     (irq),
    .wake    (wake)
  );

  assert_freeze_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(count));

  assert_no_irq_idle_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (!irq && !wake));
endmodule

// File: tb/sleep_timer_tb.sv
`timescale 1ns/1ps
module sleep_timer_tb;
  localparam int CNT_W = 8;
  localparam int EXP_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_1k = 1'b0;
  logic             tick_32k = 1'b0;
  logic             src_sel = 1'b0;
  logic [EXP_W-1:0] pre_exp = '0;
  logic [CNT_W-1:0] cmp0_val = '0;
  logic [CNT_W-1:0] cmp1_val = '0;
  logic [2:0]       irq_en = '0;
  logic [2:0]       wake_en = '0;
  logic [2:0]       flag_clr = '0;
  logic             dbg_halt = 1'b0;
  logic             freeze_en = 1'b0;
  logic [CNT_W-1:0] count;
  logic [2:0]       flags;
  logic             irq;
  logic             wake;

  always #2.5 clk = ~clk;

  sleep_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .tick_32k(tick_32k),
    .src_sel(src_sel), .pre_exp(pre_exp), .cmp0_val(cmp0_val),
    .cmp1_val(cmp1_val), .irq_en(irq_en), .wake_en(wake_en),
    .flag_clr(flag_clr), .dbg_halt(dbg_halt), .freeze_en(freeze_en),
    .count(count), .flags(flags), .irq(irq), .wake(wake)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  string       phase = "R10";
  bit          done = 0;

  logic [CNT_W-1:0] m_cnt = '0;
  logic [2:0]       m_flags = '0;
  int               m_pre = 0;
  logic             m_src = 1'b0;
  int               m_exp = 0;

  task automatic check_all();
    logic exp_irq, exp_wake;
    exp_irq  = |(m_flags & irq_en);
    exp_wake = |(m_flags & wake_en);
    n_vec++;
    if (count !== m_cnt || flags !== m_flags || irq !== exp_irq || wake !== exp_wake) begin
      n_bad++;
      $display("FAIL %s: count=%0d flags=%b irq=%b wake=%b expected count=%0d flags=%b irq=%b wake=%b",
               phase, count, flags, irq, wake, m_cnt, m_flags, exp_irq, exp_wake);
    end
  endtask

  task automatic model_edge();
    bit chg, tk, frz, adv;
    logic [2:0] set;
    logic [CNT_W-1:0] nxt;
    chg = (src_sel != m_src) || (int'(pre_exp) != m_exp);
    tk  = src_sel ? tick_32k : tick_1k;
    frz = dbg_halt && freeze_en;
    adv = 0;
    if (chg) m_pre = 0;
    else if (tk && !frz) begin
      if (m_pre == (1 << int'(pre_exp)) - 1) begin m_pre = 0; adv = 1; end
      else m_pre = m_pre + 1;
    end
    set = '0;
    if (adv) begin
      if (m_cnt == {CNT_W{1'b1}}) set[2] = 1'b1;
      nxt = m_cnt + 1'b1;
      if (nxt == cmp0_val) set[0] = 1'b1;
      if (nxt == cmp1_val) set[1] = 1'b1;
      m_cnt = nxt;
    end
    m_flags = (m_flags & ~flag_clr) | set;
    m_src = src_sel;
    m_exp = int'(pre_exp);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout at %0d cycles, expected completion", cyc);
        finish_up();
      end
    end
  end

  initial begin
    // R10: reset state
    phase = "R10";
    repeat (3) @(negedge clk);
    check_all();
    rst_n = 1'b1;
    step();

    cmp0_val = 8'd5; cmp1_val = 8'd9;
    irq_en = 3'b001; wake_en = 3'b010;

    // R1: plain counting, divide by one
    phase = "R1";
    tick_1k = 1'b1;
    run(4);
    // R5: both compare channels hit as count passes 5 and 9
    phase = "R5";
    run(8);
    tick_1k = 1'b0;
    run(2);

    // R8: mask combinations
    phase = "R8";
    for (int m = 0; m < 8; m++) begin
      irq_en = 3'(m); wake_en = 3'(7 - m);
      step();
    end

    // R7: clear, then simultaneous set and clear
    phase = "R7";
    flag_clr = 3'b001; step();
    flag_clr = 3'b000; run(2);
    cmp0_val = count + 8'd1;
    flag_clr = 3'b001; tick_1k = 1'b1; step();
    flag_clr = 3'b000; tick_1k = 1'b0; run(2);
    flag_clr = 3'b011; step();
    flag_clr = 3'b000; step();

    // R5: compare equal to the held count sets nothing
    phase = "R5";
    cmp1_val = count; run(3);

    // R2: unselected source ignored
    phase = "R2";
    tick_32k = 1'b1; run(5);
    tick_32k = 1'b0;
    // R4: source change drops the tick
    phase = "R4";
    src_sel = 1'b1; tick_32k = 1'b1; step();
    phase = "R2";
    tick_1k = 1'b1; run(4);
    tick_1k = 1'b0; tick_32k = 1'b0; step();

    // R3: divide by four, continuous and sparse ticks
    phase = "R3";
    pre_exp = 4'd2; step();
    tick_32k = 1'b1; run(12);
    for (int k = 0; k < 16; k++) begin
      tick_32k = k[0]; step();
    end
    tick_32k = 1'b1; run(2);

    // R4: exponent change mid-prescale
    phase = "R4";
    pre_exp = 4'd3; step();
    run(10);
    src_sel = 1'b0; tick_1k = 1'b1; step();
    tick_32k = 1'b0; run(9);

    // R9: halt without and with freeze enable
    phase = "R9";
    dbg_halt = 1'b1; run(10);
    freeze_en = 1'b1; run(10);
    dbg_halt = 1'b0; run(8);
    freeze_en = 1'b0;

    // R6: roll over with divide by one
    phase = "R6";
    pre_exp = 4'd0; irq_en = 3'b100; wake_en = 3'b100;
    flag_clr = 3'b111; step();
    flag_clr = 3'b000;
    run(300);
    tick_1k = 1'b0; run(2);

    // R3: largest divide
    phase = "R3";
    pre_exp = 4'd15; step();
    tick_1k = 1'b1; run(32770);
    tick_1k = 1'b0; run(2);

    finish_up();
  end
endmodule